// File: doc/BRIEF.md
# Two-Host OOB Presence Detect and Arbiter

This block decides which of two hosts owns a single downstream device when ownership is negotiated through out-of-band signalling. It receives decoded OOB indications from each host port (reset-sequence active, wake sequence detected and the raw squelch detector level) and a decoded init indication from the device. From these it keeps an active-host state with three values: none, host 0 or host 1. The state drives the device-side transmit enable and the routing masks that say which host's OOB traffic may reach the device and which hosts hear the device's OOB traffic.

Each host port has its own wake-burst sequencer. It sends a presence-announcing wake sequence once reset is released, and again after every reset sequence that the host sends. The sequence is a counted train of bursts and gaps on a timing tick. When a host becomes the owner, or when the owner sends a reset sequence, a reset request toward the device is held on until that host's wake sequence has finished. This keeps the device's init response from landing while the wake sequence would hide it. A separate selection-signal detector supplies per-port switch requests, which move ownership to the non-owning host.

Top module: `oob_host_arbiter`

## Requirements
- R1: While reset is asserted and after it, before any OOB event, `act_state` is 2'b00 (none; 2'b01 = host 0, 2'b10 = host 1), `dev_tx_en` is 0, `fwd_up` is 2'b00, `fwd_down` is 2'b11, `sel_status` is 1 and `dev_reset_req` is 0.
- R2: After reset is released, each host's `wake_burst` bit rises in the first cycle after release. It then runs BURSTS bursts of BURST_TICKS ticks, each followed by a gap of GAP_TICKS ticks. `wake_done` for that host rises in the cycle after the last gap tick.
- R3: While `host_reset_act[i]` is high, host i's sequencer is held armed, with `wake_burst[i]` and `wake_done[i]` low. It starts a new sequence in the first cycle after `host_reset_act[i]` falls, whether or not host i is active. The other host's sequencer is not affected.
- R4: With no host active, a wake or reset indication on one host makes that host active from the next cycle.
- R5: With no host active, indications on both hosts in the same cycle select host 0.
- R6: `dev_reset_req` follows the active host's `host_reset_act`. It is also held high from the cycle after a host becomes active, or after the active host asserts `host_reset_act`, until the cycle after that host's `wake_done` is high. The inactive host's reset indication never reaches it.
- R7: `fwd_up` is one-hot for the active host (bit i = host i) and 0 with none. `fwd_down` is 2'b11 with none and one-hot for the active host otherwise. `dev_tx_en` is high whenever a host is active.
- R8: `sel_status` is low only while host 1 is active. `oob_flag` equals `host_sq[0]` with none active, and otherwise the squelch input of the inactive host.
- R9: `sw_req[i]` for the inactive host i makes host i active in the next cycle. `sw_req` for the active host, and wake or reset indications from the inactive host, leave the active host unchanged.
- R10: `host_init_out` is `dev_init_det` masked by `fwd_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Burst timing tick enable |
| host_reset_act | input | 2 | Host i reset sequence being received |
| host_wake_det | input | 2 | Host i wake sequence detected |
| host_sq | input | 2 | Host i squelch detector level |
| dev_init_det | input | 1 | Device init sequence detected |
| sw_req | input | 2 | Switch request for host i from the selection detector |
| wake_burst | output | 2 | Host i wake burst being sent |
| wake_done | output | 2 | Host i wake sequence finished |
| dev_reset_req | output | 1 | Send reset sequence toward the device |
| act_state | output | 2 | Active host: 00 none, 01 host 0, 10 host 1 |
| dev_tx_en | output | 1 | Device-side transmitter enable |
| fwd_up | output | 2 | Host i OOB forwarded to the device |
| fwd_down | output | 2 | Device OOB forwarded to host i |
| host_init_out | output | 2 | Device init forwarded to host i |
| sel_status | output | 1 | High unless host 1 is active |
| oob_flag | output | 1 | Squelch level of the inactive host |

## Verification
Two pairs of functions can act in the same cycle. The first is a simultaneous first indication on both hosts while none is active; the bench raises both wake bits in one cycle and expects host 0 to own the device in the next. The second is a switch request for host 1 in the cycle that host 1 starts a reset sequence. The bench expects ownership to move at once, the reset to reach the device from the following cycle, and the device request to stay held until host 1's restarted wake train ends, with each cycle predicted from the burst arithmetic.

// File: rtl/oob_arb_pkg.sv
`timescale 1ns/1ps
package oob_arb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_H0   = 2'b01,
    ACT_H1   = 2'b10
  } act_e;

  typedef enum logic [1:0] {
    WK_ARM   = 2'b00,
    WK_BURST = 2'b01,
    WK_GAP   = 2'b10,
    WK_DONE  = 2'b11
  } wake_st_e;

  // Next owner from current owner, first-event vector and switch requests.
  function automatic act_e next_act(act_e cur, logic [1:0] ev, logic [1:0] sw);
    case (cur)
      ACT_NONE: next_act = ev[0] ? ACT_H0 : (ev[1] ? ACT_H1 : ACT_NONE);
      ACT_H0:   next_act = sw[1] ? ACT_H1 : ACT_H0;
      ACT_H1:   next_act = sw[0] ? ACT_H0 : ACT_H1;
      default:  next_act = ACT_NONE;
    endcase
  endfunction

  // True when a tick counter sits on the last tick of a phase of length len.
  function automatic logic last_tick(int unsigned cnt, int unsigned len);
    last_tick = (cnt + 1 == len);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    max2 = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/oob_wake_gen.sv
`timescale 1ns/1ps
module oob_wake_gen
  import oob_arb_pkg::*;
#(
  parameter int unsigned BURSTS      = 6,
  parameter int unsigned BURST_TICKS = 4,
  parameter int unsigned GAP_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic reset_act,
  output logic burst_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(max2(BURST_TICKS, GAP_TICKS) + 1);
  localparam int unsigned IW = $clog2(BURSTS + 1);

  wake_st_e        st;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic            phase_end;
  logic            train_end;

  assign phase_end = tick && ((st == WK_BURST) ? last_tick(int'(cnt), BURST_TICKS)
                                               : last_tick(int'(cnt), GAP_TICKS));
  assign train_end = last_tick(int'(idx), BURSTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= WK_ARM;
      cnt <= '0;
      idx <= '0;
    end else if (reset_act) begin
      st  <= WK_ARM;
      cnt <= '0;
      idx <= '0;
    end else begin
      case (st)
        WK_ARM: begin
          st  <= WK_BURST;
          cnt <= '0;
          idx <= '0;
        end
        WK_BURST: if (tick) begin
          if (phase_end) begin
            st  <= WK_GAP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        WK_GAP: if (tick) begin
          if (phase_end) begin
            cnt <= '0;
            if (train_end) st <= WK_DONE;
            else begin
              idx <= idx + 1'b1;
              st  <= WK_BURST;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= WK_DONE;
      endcase
    end
  end

  assign burst_o = (st == WK_BURST);
  assign done_o  = (st == WK_DONE);
endmodule

// File: rtl/oob_host_sel.sv
`timescale 1ns/1ps
module oob_host_sel
  import oob_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ev,
  input  logic [1:0] sw,
  output act_e       act_o,
  output logic       sel_evt_o
);
  act_e act_q;
  act_e act_d;

  assign act_d     = next_act(act_q, ev, sw);
  assign sel_evt_o = (act_d != act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= ACT_NONE;
    else        act_q <= act_d;
  end

  assign act_o = act_q;
endmodule

// File: rtl/oob_dev_reset_hold.sv
`timescale 1ns/1ps
module oob_dev_reset_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_evt,
  input  logic act_reset,
  input  logic act_done,
  output logic hold_o,
  output logic dev_reset_o
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hold_q <= 1'b0;
    else if (sel_evt || act_reset) hold_q <= 1'b1;
    else if (act_done)             hold_q <= 1'b0;
  end

  assign hold_o      = hold_q;
  assign dev_reset_o = hold_q | act_reset;
endmodule

// File: rtl/oob_host_arbiter.sv
`timescale 1ns/1ps
module oob_host_arbiter
  import oob_arb_pkg::*;
#(
  parameter int unsigned BURSTS      = 6,
  parameter int unsigned BURST_TICKS = 4,
  parameter int unsigned GAP_TICKS   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] host_reset_act,
  input  logic [1:0] host_wake_det,
  input  logic [1:0] host_sq,
  input  logic       dev_init_det,
  input  logic [1:0] sw_req,
  output logic [1:0] wake_burst,
  output logic [1:0] wake_done,
  output logic       dev_reset_req,
  output logic [1:0] act_state,
  output logic       dev_tx_en,
  output logic [1:0] fwd_up,
  output logic [1:0] fwd_down,
  output logic [1:0] host_init_out,
  output logic       sel_status,
  output logic       oob_flag
);
  act_e       act;
  logic       sel_evt;
  logic [1:0] host_ev;
  logic       act_reset;
  logic       act_done;
  logic       hold;

  for (genvar h = 0; h < 2; h++) begin : g_wake
    oob_wake_gen #(
      .BURSTS(BURSTS), .BURST_TICKS(BURST_TICKS), .GAP_TICKS(GAP_TICKS)
    ) u_wake (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .reset_act(host_reset_act[h]),
      .burst_o(wake_burst[h]), .done_o(wake_done[h])
    );
  end

  assign host_ev = host_reset_act | host_wake_det;

  oob_host_sel u_sel (
    .clk(clk), .rst_n(rst_n), .ev(host_ev), .sw(sw_req),
    .act_o(act), .sel_evt_o(sel_evt)
  );

  assign fwd_up    = act;
  assign act_reset = |(host_reset_act & fwd_up);
  assign act_done  = |(wake_done & fwd_up);

  oob_dev_reset_hold u_hold (
    .clk(clk), .rst_n(rst_n), .sel_evt(sel_evt),
    .act_reset(act_reset), .act_done(act_done),
    .hold_o(hold), .dev_reset_o(dev_reset_req)
  );

  assign act_state     = act;
  assign dev_tx_en     = (act != ACT_NONE);
  assign fwd_down      = (act == ACT_NONE) ? 2'b11 : fwd_up;
  assign host_init_out = {2{dev_init_det}} & fwd_down;
  assign sel_status    = (act != ACT_H1);
  assign oob_flag      = (act == ACT_H0) ? host_sq[1] : host_sq[0];
endmodule

// File: rtl/oob_host_arbiter_chk.sv
`timescale 1ns/1ps
module oob_host_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] act,
  input logic [1:0] host_reset_act,
  input logic [1:0] host_wake_det,
  input logic [1:0] sw_req,
  input logic [1:0] wake_burst,
  input logic [1:0] wake_done,
  input logic       dev_reset_req,
  input logic       dev_tx_en,
  input logic [1:0] fwd_down
);
  logic [1:0] ev;
  assign ev = host_reset_act | host_wake_det;

  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_first_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b00 && ev[1] && !ev[0]) |=> act == 2'b10);

  p_tie_host0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b00 && ev[0]) |=> act == 2'b01);

  p_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b01 && sw_req[1]) |=> act == 2'b10);

  p_keep_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b10 && !sw_req[0]) |=> act == 2'b10);

  p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act != 2'b00 && !(|(wake_done & act))) |-> dev_reset_req);

  p_armed_h0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_reset_act[0] |=> (!wake_burst[0] && !wake_done[0]));

  p_armed_h1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_reset_act[1] |=> (!wake_burst[1] && !wake_done[1]));

  p_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_en |-> $countones(fwd_down) == 1);
endmodule

bind oob_host_arbiter oob_host_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act(act_state),
  .host_reset_act(host_reset_act), .host_wake_det(host_wake_det),
  .sw_req(sw_req), .wake_burst(wake_burst), .wake_done(wake_done),
  .dev_reset_req(dev_reset_req), .dev_tx_en(dev_tx_en), .fwd_down(fwd_down)
);

// File: tb/test_oob_host_arbiter.sv
`timescale 1ns/1ps
module test_oob_host_arbiter;
  localparam int NB = 3;
  localparam int BT = 2;
  localparam int GT = 3;
  localparam int TL = NB * (BT + GT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [1:0] host_reset_act = '0, host_wake_det = '0, host_sq = '0, sw_req = '0;
  logic dev_init_det = 1'b0;
  logic [1:0] wake_burst, wake_done, act_state, fwd_up, fwd_down, host_init_out;
  logic dev_reset_req, dev_tx_en, sel_status, oob_flag;

  always #2.5 clk = ~clk;

  oob_host_arbiter #(.BURSTS(NB), .BURST_TICKS(BT), .GAP_TICKS(GT)) i_oob_host_arbiter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_reset_act(host_reset_act),
    .host_wake_det(host_wake_det), .host_sq(host_sq), .dev_init_det(dev_init_det),
    .sw_req(sw_req), .wake_burst(wake_burst), .wake_done(wake_done),
    .dev_reset_req(dev_reset_req), .act_state(act_state), .dev_tx_en(dev_tx_en),
    .fwd_up(fwd_up), .fwd_down(fwd_down), .host_init_out(host_init_out),
    .sel_status(sel_status), .oob_flag(oob_flag)
  );

  typedef struct {
    int    due;
    int    fid;
    int    val;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int field(int fid);
    case (fid)
      0: field = int'(act_state);
      1: field = int'(dev_tx_en);
      2: field = int'(fwd_up);
      3: field = int'(fwd_down);
      4: field = int'(sel_status);
      5: field = int'(oob_flag);
      6: field = int'(dev_reset_req);
      7: field = int'(wake_burst[0]);
      8: field = int'(wake_burst[1]);
      9: field = int'(wake_done[0]);
      10: field = int'(wake_done[1]);
      11: field = int'(host_init_out);
      default: field = -1;
    endcase
  endfunction

  // Scoreboard monitor: compare every item due in this cycle.
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].due == cyc) begin
        n_cmp++;
        if (field(exp_q[i].fid) != exp_q[i].val) begin
          n_bad++;
          $display("FAIL %s cycle %0d field %0d: got %0d expected %0d",
                   exp_q[i].req, cyc, exp_q[i].fid, field(exp_q[i].fid), exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic push(int due, int fid, int val, string req);
    exp_t e;
    e.due = due; e.fid = fid; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Expected wake train of one host starting at cycle s.
  task automatic exp_wake(int h, int s, string req);
    for (int k = 0; k <= TL; k++) begin
      push(s + k, 7 + h, (k < TL && (k % (BT + GT)) < BT) ? 1 : 0, req);
      push(s + k, 9 + h, (k >= TL) ? 1 : 0, req);
    end
  endtask

  task automatic exp_owner(int due, int a, string req);
    push(due, 0, a, req);
    push(due, 1, (a != 0) ? 1 : 0, "R7");
    push(due, 2, a, "R7");
    push(due, 3, (a == 0) ? 3 : a, "R7");
    push(due, 4, (a == 2) ? 0 : 1, "R8");
  endtask

  initial begin
    int t;
    step(2);
    // R1: reset state
    exp_owner(cyc, 0, "R1");
    push(cyc, 6, 0, "R1");
    step(1);
    rst_n = 1'b1;
    exp_wake(0, cyc + 1, "R2");
    exp_wake(1, cyc + 1, "R2");
    exp_owner(cyc + 1, 0, "R1");
    step(2);
    // R10: no owner, device init goes to both hosts
    dev_init_det = 1'b1;
    push(cyc, 11, 3, "R10");
    step(1);
    dev_init_det = 1'b0;
    step(TL + 2);

    // R5: both hosts in one cycle -> host 0
    host_wake_det = 2'b11;
    host_sq = 2'b10;
    push(cyc, 5, 0, "R8");
    t = cyc;
    exp_owner(t + 1, 1, "R5");
    push(t + 1, 6, 1, "R6");
    push(t + 2, 6, 0, "R6");
    push(t + 1, 5, 1, "R8");
    step(1);
    host_wake_det = 2'b00;
    step(1);
    host_sq = 2'b01;
    push(cyc, 5, 0, "R8");
    step(2);

    // R3/R6: COMRESET on active host 0 for 3 cycles
    host_reset_act = 2'b01;
    t = cyc;
    push(t, 6, 1, "R6");
    push(t + 1, 9, 0, "R3");
    push(t + 2, 7, 0, "R3");
    step(3);
    host_reset_act = 2'b00;
    exp_wake(0, t + 4, "R3");
    push(t + 4, 8, 0, "R3");
    push(t + 4, 10, 1, "R3");
    push(t + 3 + TL, 6, 1, "R6");
    push(t + 4 + TL, 6, 1, "R6");
    push(t + 5 + TL, 6, 0, "R6");
    step(TL + 8);

    // R3/R9: COMRESET on inactive host 1, not forwarded, no reselection
    host_reset_act = 2'b10;
    dev_init_det = 1'b1;
    t = cyc;
    push(t, 11, 1, "R10");
    push(t, 6, 0, "R6");
    push(t + 1, 6, 0, "R6");
    exp_owner(t + 1, 1, "R9");
    exp_owner(t + 2, 1, "R9");
    step(1);
    dev_init_det = 1'b0;
    step(1);
    host_reset_act = 2'b00;
    exp_wake(1, t + 3, "R3");
    step(TL + 6);

    // R9: switch request for the active host is ignored
    sw_req = 2'b01;
    exp_owner(cyc + 1, 1, "R9");
    step(1);
    sw_req = 2'b00;
    step(1);

    // R9 + R6: switch to host 1 in the cycle host 1 starts COMRESET
    sw_req = 2'b10;
    host_reset_act = 2'b10;
    host_sq = 2'b01;
    t = cyc;
    push(t, 6, 0, "R6");
    exp_owner(t + 1, 2, "R9");
    push(t + 1, 6, 1, "R6");
    push(t + 1, 5, 1, "R8");
    step(1);
    sw_req = 2'b00;
    step(1);
    host_reset_act = 2'b00;
    exp_wake(1, t + 3, "R3");
    push(t + 3 + TL, 6, 1, "R6");
    push(t + 4 + TL, 6, 0, "R6");
    step(2);
    dev_init_det = 1'b1;
    push(cyc, 11, 2, "R10");
    step(1);
    dev_init_det = 1'b0;
    step(TL + 4);

    // R9: switch back to host 0 (its train already done)
    sw_req = 2'b01;
    t = cyc;
    exp_owner(t + 1, 1, "R9");
    push(t + 1, 6, 1, "R6");
    push(t + 2, 6, 0, "R6");
    step(1);
    sw_req = 2'b00;
    step(3);

    // R4: fresh reset, single wake on host 1 during power-up train
    rst_n = 1'b0;
    exp_owner(cyc, 0, "R1");
    step(1);
    rst_n = 1'b1;
    t = cyc;
    step(2);
    host_wake_det = 2'b10;
    exp_owner(cyc + 1, 2, "R4");
    step(1);
    host_wake_det = 2'b00;
    push(t + 1 + TL, 6, 1, "R6");
    push(t + 2 + TL, 6, 0, "R6");
    step(TL + 4);

    if (exp_q.size() != 0) begin
      n_bad += exp_q.size();
      $display("FAIL scoreboard: %0d items never compared, expected 0", exp_q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule